// File: doc/BRIEF.md
# Reference Fault Qualification Timers

This block decides, over time, whether a single timing reference is usable. A period monitor upstream raises a raw fault flag whenever the measured reference period falls outside tolerance. The block turns that raw flag into a qualified fault status. A faulted reference is released only after it has stayed clean for a programmed number of millisecond ticks, or when a manual force command arrives. A fault on a usable reference takes effect at once.

A second timer serves automatic profile selection. It measures how long the reference has stayed continuously faulted. When that time reaches a programmed number of ticks, it emits a one-cycle request so that selection logic can try to assign the reference to another profile. Both timeouts are 16-bit tick counts. A value of zero turns the matching timer off; it does not mean a zero delay. A qualified fault status and a redetect request are the only outputs. The millisecond tick comes from outside the block.

Top module: `ref_qual_timers`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it, `fault_o` is 1 (faulted) and `redetect_o` is 0.
- R2: With `valid_to_i` = N (N > 0), `fault_o` high and `raw_fault_i` low, `fault_o` stays 1 through the clock edge that samples the Nth `tick_i` of an uninterrupted fault-free run, and goes to 0 at the next edge.
- R3: A clock edge that samples `raw_fault_i` = 1 clears the validation count, so a run of N fault-free ticks starts again from zero.
- R4: A clock edge that samples `raw_fault_i` = 1 sets `fault_o` to 1 at that edge. No tick is needed, and this takes priority over the force command and the validation timer.
- R5: With `valid_to_i` = 0 the validation timer is off, and no number of ticks clears `fault_o`.
- R6: A clock edge that samples `force_valid_i` = 1 with `raw_fault_i` = 0 clears `fault_o` at that edge, whatever the value of `valid_to_i`. When `raw_fault_i` = 1, `force_valid_i` has no effect.
- R7: With `auto_mode_i` = 1 and `redet_to_i` = N (N > 0), `redetect_o` is 1 for the cycle after the edge that samples the Nth `tick_i` of a run in which `fault_o` stays 1. It is 0 after the earlier ticks.
- R8: `redetect_o` is 1 for one cycle only, and the timer then re-arms. While the fault persists, another pulse follows after another N ticks.
- R9: `redetect_o` stays 0 when `auto_mode_i` = 0 or `redet_to_i` = 0.
- R10: Any cycle with `fault_o` = 0 clears the redetect count. A later faulted run needs N new ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| raw_fault_i | input | 1 | Unqualified fault flag from the period monitor |
| valid_to_i | input | 16 | Validation timeout in ticks; 0 disables the timer |
| redet_to_i | input | 16 | Redetect timeout in ticks; 0 disables the timer |
| auto_mode_i | input | 1 | Automatic profile selection is enabled |
| force_valid_i | input | 1 | Manual validation command |
| fault_o | output | 1 | Qualified fault status, 1 = faulted |
| redetect_o | output | 1 | One-cycle profile reassignment request |

## Verification
The validation timer is swept over timeouts 1 to 6. Each sweep checks that the output holds through tick N and clears one cycle later, which separates an off-by-one in the compare from an extra register stage. A run broken by a raw fault shows whether the count restarts or only pauses. Force commands are applied with the raw flag both clean and set, to show that a raw fault overrides them. The redetect timer is swept over timeouts 1 to 5 with two pulses per setting, which covers re-arming. It is also run with the mode off, with a zero timeout, and across a brief valid interval, to show that an interrupted faulted run does not carry its count forward.

// File: rtl/ref_qual_pkg.sv
package ref_qual_pkg;
  localparam int unsigned TMR_W = 16;
  typedef logic [TMR_W-1:0] tmr_t;
endpackage

// File: rtl/qual_timer.sv
// Counts ticks while run_i holds; done_o pulses on the limit-th tick.
module qual_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic         off;

  assign off = (limit_i == '0) || !run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (off) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == limit_i - W'(1)) begin
        cnt_q  <= '0;
        done_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + W'(1);
        done_o <= 1'b0;
      end
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ref_fault_state.sv
// Qualified fault flag: raw fault sets at once, release by timer or force.
module ref_fault_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_fault_i,
  input  logic release_i,
  input  logic force_i,
  output logic fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    fault_o <= 1'b1;
    else if (raw_fault_i)           fault_o <= 1'b1;
    else if (release_i || force_i)  fault_o <= 1'b0;
  end
endmodule

// File: rtl/ref_qual_timers.sv
module ref_qual_timers
  import ref_qual_pkg::*;
#(
  parameter int unsigned TMR_W = ref_qual_pkg::TMR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             raw_fault_i,
  input  logic [TMR_W-1:0] valid_to_i,
  input  logic [TMR_W-1:0] redet_to_i,
  input  logic             auto_mode_i,
  input  logic             force_valid_i,
  output logic             fault_o,
  output logic             redetect_o
);
  localparam int unsigned N_TMR = 2;
  localparam int unsigned T_VAL = 0;
  localparam int unsigned T_RDT = 1;

  logic [N_TMR-1:0] run;
  logic [N_TMR-1:0] done;
  logic [TMR_W-1:0] limit [N_TMR];

  assign run[T_VAL]   = fault_o && !raw_fault_i;
  assign run[T_RDT]   = fault_o && auto_mode_i;
  assign limit[T_VAL] = valid_to_i;
  assign limit[T_RDT] = redet_to_i;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    qual_timer #(.W(TMR_W)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run[g]),
      .tick_i (tick_i),
      .limit_i(limit[g]),
      .done_o (done[g])
    );
  end

  ref_fault_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .raw_fault_i(raw_fault_i),
    .release_i  (done[T_VAL]),
    .force_i    (force_valid_i),
    .fault_o    (fault_o)
  );

  assign redetect_o = done[T_RDT];
endmodule

// File: rtl/ref_qual_chk.sv
module ref_qual_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         raw_fault_i,
  input logic [W-1:0] valid_to_i,
  input logic [W-1:0] redet_to_i,
  input logic         auto_mode_i,
  input logic         force_valid_i,
  input logic         fault_o,
  input logic         redetect_o
);
  assert_raw_sets_fault_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_fault_i |=> fault_o);

  assert_no_redet_manual_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_mode_i |=> !redetect_o);

  assert_no_redet_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redet_to_i == '0) |=> !redetect_o);

  assert_redet_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redetect_o |-> $past(tick_i));

  assert_redet_when_faulted_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redetect_o |-> $past(fault_o));

  assert_force_blocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && force_valid_i && raw_fault_i) |=> fault_o);
endmodule

bind ref_qual_timers ref_qual_chk #(.W(TMR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .raw_fault_i  (raw_fault_i),
  .valid_to_i   (valid_to_i),
  .redet_to_i   (redet_to_i),
  .auto_mode_i  (auto_mode_i),
  .force_valid_i(force_valid_i),
  .fault_o      (fault_o),
  .redetect_o   (redetect_o)
);

// File: tb/ref_qual_timers_tb.sv
`timescale 1ns/1ps
module ref_qual_timers_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        raw_fault_i = 1'b1;
  logic [15:0] valid_to_i = '0;
  logic [15:0] redet_to_i = '0;
  logic        auto_mode_i = 1'b0;
  logic        force_valid_i = 1'b0;
  logic        fault_o;
  logic        redetect_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  ref_qual_timers dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .raw_fault_i(raw_fault_i),
    .valid_to_i(valid_to_i), .redet_to_i(redet_to_i), .auto_mode_i(auto_mode_i),
    .force_valid_i(force_valid_i), .fault_o(fault_o), .redetect_o(redetect_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock; starts and ends at a falling edge
  task automatic cyc(input logic t);
    tick_i = t;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 fault in reset", fault_o, 1'b1);
    chk("R1 redetect in reset", redetect_o, 1'b0);
    rst_ni = 1'b1;
    cyc(0);
    chk("R1 fault after reset", fault_o, 1'b1);
    chk("R1 redetect after reset", redetect_o, 1'b0);

    // R2 validation sweep
    for (int n = 1; n <= 6; n++) begin
      valid_to_i = 16'(n);
      raw_fault_i = 1'b1; cyc(0); raw_fault_i = 1'b0;
      for (int k = 1; k < n; k++) begin
        cyc(1);
        chk("R2 held before tick N", fault_o, 1'b1);
      end
      cyc(1);
      chk("R2 held at tick N", fault_o, 1'b1);
      cyc(0);
      chk("R2 cleared after tick N", fault_o, 1'b0);
    end

    // R4 immediate fault
    raw_fault_i = 1'b1; cyc(0);
    chk("R4 raw fault sets at once", fault_o, 1'b1);

    // R3 restart on interruption
    valid_to_i = 16'd4;
    raw_fault_i = 1'b0;
    for (int k = 0; k < 3; k++) cyc(1);
    raw_fault_i = 1'b1; cyc(0); raw_fault_i = 1'b0;
    for (int k = 0; k < 3; k++) cyc(1);
    cyc(0);
    chk("R3 count restarted", fault_o, 1'b1);
    cyc(1); cyc(0);
    chk("R3 valid after fresh run", fault_o, 1'b0);

    // R4 priority over force
    raw_fault_i = 1'b1; force_valid_i = 1'b1; cyc(0);
    chk("R4 raw beats force", fault_o, 1'b1);
    force_valid_i = 1'b0;

    // R5 disabled validation timer
    valid_to_i = '0;
    raw_fault_i = 1'b0;
    for (int k = 0; k < 20; k++) cyc(1);
    cyc(0);
    chk("R5 no release with zero timeout", fault_o, 1'b1);

    // R6 force
    raw_fault_i = 1'b1; force_valid_i = 1'b1; cyc(0);
    chk("R6 force ignored under raw fault", fault_o, 1'b1);
    raw_fault_i = 1'b0; cyc(0); force_valid_i = 1'b0;
    chk("R6 force clears fault", fault_o, 1'b0);
    cyc(0);
    chk("R6 stays valid", fault_o, 1'b0);
    raw_fault_i = 1'b1; cyc(0);
    valid_to_i = 16'd9;
    raw_fault_i = 1'b0; force_valid_i = 1'b1; cyc(0); force_valid_i = 1'b0;
    chk("R6 force with timer enabled", fault_o, 1'b0);

    // R7/R8 redetect sweep; validation off, reference faulted
    valid_to_i = '0;
    raw_fault_i = 1'b1;
    for (int n = 1; n <= 5; n++) begin
      auto_mode_i = 1'b0; redet_to_i = 16'(n); cyc(0); auto_mode_i = 1'b1;
      for (int rep = 0; rep < 2; rep++) begin
        for (int k = 1; k < n; k++) begin
          cyc(1);
          chk("R7 no request before tick N", redetect_o, 1'b0);
          cyc(0);
        end
        cyc(1);
        chk(rep == 0 ? "R7 request at tick N" : "R8 re-armed request", redetect_o, 1'b1);
        cyc(0);
        chk("R8 request lasts one cycle", redetect_o, 1'b0);
      end
    end

    // R9 mode off / zero timeout
    begin
      logic seen;
      seen = 1'b0;
      auto_mode_i = 1'b0; redet_to_i = 16'd2;
      for (int k = 0; k < 10; k++) begin cyc(1); seen |= redetect_o; end
      chk("R9 no request in manual mode", seen, 1'b0);
      seen = 1'b0;
      auto_mode_i = 1'b1; redet_to_i = '0;
      for (int k = 0; k < 10; k++) begin cyc(1); seen |= redetect_o; end
      chk("R9 no request with zero timeout", seen, 1'b0);
    end

    // R10 valid interval clears redetect count
    auto_mode_i = 1'b0; redet_to_i = 16'd4; cyc(0); auto_mode_i = 1'b1;
    for (int k = 0; k < 3; k++) begin cyc(1); cyc(0); end
    raw_fault_i = 1'b0; force_valid_i = 1'b1; cyc(0); force_valid_i = 1'b0;
    chk("R10 forced valid", fault_o, 1'b0);
    raw_fault_i = 1'b1; cyc(0);
    for (int k = 0; k < 3; k++) begin
      cyc(1);
      chk("R10 count restarted", redetect_o, 1'b0);
      cyc(0);
    end
    cyc(1);
    chk("R10 request after fresh run", redetect_o, 1'b1);
    cyc(0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule